// File: doc/BRIEF.md
# Program Counter with Return Stack

This block produces the instruction fetch address for a small 8-bit controller whose program memory holds 14-bit words. It keeps an 11-bit program counter. On every advanced instruction cycle the counter moves on by one. It can instead load a branch target supplied by the instruction decoder, or restore a return address from a small hardware return stack. The decoder delivers one-cycle request strobes for call, jump, return and skip, plus an 11-bit target taken from the instruction word. The fetch sequencer uses the registered address to read program memory.

Fetch runs one word ahead of execution. When a branch is taken, the word already fetched is stale, so the block raises a flush flag for one instruction cycle. While that flag is high, the stale word executes as a bubble, and any request the decoder derives from it is ignored. Each taken branch therefore costs exactly two cycles.

The return stack has a fixed depth of four and no error signalling. A push beyond four levels overwrites the oldest entry. A pop from an empty stack returns whatever the slot below the pointer still holds. For parts with smaller program memory, a parameter sets how many low address bits are live, and the bits above them are held at zero.

Top module: `pc_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, fetchAddr is all ones within the live address width (3FFh when PROG_BITS is 10) and flush is 0. The stack pointer is empty at that point.
- R2: In an advanced cycle with no request and flush low, fetchAddr increases by one after the clock edge. It wraps from the highest live address to 000h.
- R3: A jump request, taken in an advanced cycle with flush low, sets fetchAddr to target after the edge and raises flush for the next cycle.
- R4: A call request, taken in the same conditions, pushes the current fetchAddr onto the return stack, sets fetchAddr to target, and raises flush.
- R5: A return request, taken in the same conditions, sets fetchAddr to the most recently pushed address that has not yet been popped (last in, first out) and raises flush.
- R6: A skip request, taken in the same conditions, increments fetchAddr by one and raises flush, so the already fetched word is discarded.
- R7: flush stays high for exactly one advanced cycle. In that cycle every request is ignored, fetchAddr increments by one, and flush then returns to 0.
- R8: While advance is 0, fetchAddr, flush and the return stack hold their values, and all requests are ignored.
- R9: When several requests arrive in one cycle, exactly one is taken, in this priority order: call, then jump, then return, then skip.
- R10: The stack pointer wraps modulo four. A fifth nested call overwrites the oldest entry. A return with no valid entry reloads the stale slot below the pointer. Neither case is signalled.
- R11: Address bits at and above PROG_BITS are always 0. A target is masked to the live width before it is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | Instruction-cycle strobe; state changes only when it is 1 |
| callReq | input | 1 | Decoded long call request |
| jumpReq | input | 1 | Decoded long jump request (also used for writes to the low counter byte) |
| retReq | input | 1 | Decoded return request |
| skipReq | input | 1 | Decoded skip-next-instruction request |
| target | input | ADDR_W (11) | Branch target from the instruction word |
| fetchAddr | output | ADDR_W (11) | Registered program memory fetch address |
| flush | output | 1 | High for the one bubble cycle that follows a taken branch or skip |

## Verification
Both outputs are registered. A request presented in an advanced cycle therefore shows up on fetchAddr and flush just after the next rising edge, and flush falls one advanced edge after that. The bench drives every input on the falling edge and compares both outputs against its behavioural model on the following falling edge, which is exactly one register stage after the edge that consumed the stimulus. Each comparison is tagged with the requirement that the stimulus of the previous cycle exercised. Held cycles, bubble cycles carrying ignored requests, and stack wrap sequences all go through the same per-cycle comparison.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Strobes that the control unit sends to the address datapath.
  typedef struct packed {
    logic incr;     // advance the counter by one
    logic loadTgt;  // take the branch target
    logic loadTop;  // take the top return-stack entry
    logic push;     // store current address on the stack
    logic pop;      // drop the top stack entry
  } pcStrobes_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic       callReq,
  input  logic       jumpReq,
  input  logic       retReq,
  input  logic       skipReq,
  output pcStrobes_t strb,
  output logic       flush
);

  logic flushQ;
  logic anyReq;
  logic takenBr;

  assign anyReq  = callReq | jumpReq | retReq | skipReq;
  assign takenBr = advance & ~flushQ & anyReq;

  always_comb begin
    strb = '0;
    if (advance) begin
      if (flushQ) begin
        strb.incr = 1'b1;
      end else if (callReq) begin
        strb.loadTgt = 1'b1;
        strb.push    = 1'b1;
      end else if (jumpReq) begin
        strb.loadTgt = 1'b1;
      end else if (retReq) begin
        strb.loadTop = 1'b1;
        strb.pop     = 1'b1;
      end else begin
        strb.incr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flushQ <= 1'b0;
    else if (advance) flushQ <= takenBr;
  end

  assign flush = flushQ;

  assert_flush_after_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !flush && (jumpReq || callReq || retReq || skipReq)) |=> flush);

  assert_flush_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && flush) |=> !flush);

  assert_hold_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(flush));

  assert_one_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.incr, strb.loadTgt, strb.loadTop}));

endmodule

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PROG_BITS = 11,
  parameter int DEPTH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcStrobes_t        strb,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam int SP_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'((64'd1 << PROG_BITS) - 64'd1);

  logic [ADDR_W-1:0]             pcQ;
  logic [ADDR_W-1:0]             pcNext;
  logic [SP_W-1:0]               spQ;
  logic [SP_W-1:0]               topIdx;
  logic [DEPTH-1:0][ADDR_W-1:0]  stkFlat;
  logic [ADDR_W-1:0]             topVal;

  assign topIdx = spQ - 1'b1;
  assign topVal = stkFlat[topIdx];

  // One register per stack level.
  for (genvar g = 0; g < DEPTH; g++) begin : gen_level
    logic [ADDR_W-1:0] entryQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              entryQ <= '0;
      else if (strb.push && spQ == SP_W'(g))   entryQ <= pcQ;
    end
    assign stkFlat[g] = entryQ;
  end

  always_comb begin
    pcNext = pcQ;
    if (strb.loadTgt)      pcNext = target & MASK;
    else if (strb.loadTop) pcNext = topVal & MASK;
    else if (strb.incr)    pcNext = (pcQ + 1'b1) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcQ <= MASK;
      spQ <= '0;
    end else begin
      pcQ <= pcNext;
      if (strb.push)     spQ <= spQ + 1'b1;
      else if (strb.pop) spQ <= spQ - 1'b1;
    end
  end

  assign fetchAddr = pcQ;

  assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.incr |=> pcQ == (($past(pcQ) + 1'b1) & MASK));

  assert_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadTgt |=> pcQ == ($past(target) & MASK));

  assert_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.push |=> stkFlat[$past(spQ)] == $past(pcQ));

  assert_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadTop |=> pcQ == ($past(topVal) & MASK));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == '0) |=> ($stable(pcQ) && $stable(spQ)));

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pcQ & ~MASK) == '0);

endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pcseq_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PROG_BITS = 11,
  parameter int DEPTH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              callReq,
  input  logic              jumpReq,
  input  logic              retReq,
  input  logic              skipReq,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              flush
);

  pcStrobes_t strb;

  pcseq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .callReq (callReq),
    .jumpReq (jumpReq),
    .retReq  (retReq),
    .skipReq (skipReq),
    .strb    (strb),
    .flush   (flush)
  );

  pcseq_datapath #(
    .ADDR_W    (ADDR_W),
    .PROG_BITS (PROG_BITS),
    .DEPTH     (DEPTH)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .target    (target),
    .fetchAddr (fetchAddr)
  );

endmodule

// File: tb/sim_pc_seq.sv
module sim_pc_seq;

  localparam int AW  = 11;
  localparam int PB  = 10;
  localparam int MSK = (1 << PB) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          advance, callReq, jumpReq, retReq, skipReq;
  logic [AW-1:0] target;
  logic [AW-1:0] fetchAddr;
  logic          flush;

  always #2 clk = ~clk;

  pc_seq #(.ADDR_W(AW), .PROG_BITS(PB), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .advance(advance), .callReq(callReq),
    .jumpReq(jumpReq), .retReq(retReq), .skipReq(skipReq),
    .target(target), .fetchAddr(fetchAddr), .flush(flush)
  );

  // Behavioural reference model.
  int    mPc;
  bit    mFlush;
  int    mStk [4];
  int    mSp;
  int    checks = 0;
  int    errors = 0;
  string lastTag = "R1";
  bit    done = 1'b0;

  initial for (int i = 0; i < 4; i++) mStk[i] = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPc = MSK; mFlush = 1'b0; mSp = 0;
    end else if (advance) begin
      if (mFlush) begin
        mPc = (mPc + 1) & MSK; mFlush = 1'b0;
      end else if (callReq) begin
        mStk[mSp] = mPc; mSp = (mSp + 1) % 4;
        mPc = int'(target) & MSK; mFlush = 1'b1;
      end else if (jumpReq) begin
        mPc = int'(target) & MSK; mFlush = 1'b1;
      end else if (retReq) begin
        mSp = (mSp + 3) % 4; mPc = mStk[mSp]; mFlush = 1'b1;
      end else if (skipReq) begin
        mPc = (mPc + 1) & MSK; mFlush = 1'b1;
      end else begin
        mPc = (mPc + 1) & MSK;
      end
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (int'(fetchAddr) != mPc || flush !== mFlush) begin
      errors++;
      $display("FAIL %s: fetchAddr=%h flush=%b expected fetchAddr=%h flush=%b",
               tag, fetchAddr, flush, mPc[AW-1:0], mFlush);
    end
  endtask

  task automatic step(input bit a, input bit c, input bit j, input bit r,
                      input bit s, input logic [AW-1:0] t, input string tag);
    @(negedge clk);
    compare(lastTag);
    advance = a; callReq = c; jumpReq = j; retReq = r; skipReq = s; target = t;
    lastTag = tag;
  endtask

  task automatic idle(input string tag);
    step(1, 0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    advance = 0; callReq = 0; jumpReq = 0; retReq = 0; skipReq = 0; target = '0;
    repeat (3) @(negedge clk);
    // R1: reset value 3FFh with flush low, checked while reset is held.
    compare("R1");
    rst_n = 1'b1;
    idle("R2");                       // first compare checks post-reset state (R1)
    repeat (3) idle("R2");            // R2: 3FF wraps to 000 and counts up
    // R3: jump, then a bubble that carries an ignored call (R7).
    step(1, 0, 1, 0, 0, 11'h1A5, "R3");
    step(1, 1, 0, 0, 0, 11'h055, "R7");
    idle("R2");
    // R8: held cycles ignore requests.
    step(0, 1, 1, 1, 1, 11'h123, "R8");
    step(0, 0, 1, 0, 0, 11'h321, "R8");
    idle("R8");
    // R4 / R5: nested calls then returns.
    step(1, 1, 0, 0, 0, 11'h100, "R4"); idle("R7"); idle("R2");
    step(1, 1, 0, 0, 0, 11'h200, "R4"); idle("R7");
    step(1, 1, 0, 0, 0, 11'h300, "R4"); idle("R7");
    step(1, 0, 0, 1, 0, '0, "R5"); idle("R7");
    step(1, 0, 0, 1, 0, '0, "R5"); idle("R7");
    step(1, 0, 0, 1, 0, '0, "R5"); idle("R7");
    // R6: skip.
    step(1, 0, 0, 0, 1, 11'h3AA, "R6"); idle("R7");
    // R9: priority among simultaneous requests.
    step(1, 1, 1, 1, 1, 11'h0F0, "R9"); idle("R7");
    step(1, 0, 1, 1, 1, 11'h0E0, "R9"); idle("R7");
    step(1, 0, 0, 1, 1, 11'h000, "R9"); idle("R7");
    // R10: five nested calls, six returns (wrap and stale pop).
    for (int k = 0; k < 5; k++) begin
      step(1, 1, 0, 0, 0, AW'(16 * k + 3), "R10"); idle("R7");
    end
    for (int k = 0; k < 6; k++) begin
      step(1, 0, 0, 1, 0, '0, "R10"); idle("R7");
    end
    // R11: targets with bits above the live width set.
    step(1, 0, 1, 0, 0, 11'h7FF, "R11"); idle("R7");
    step(1, 1, 0, 0, 0, 11'h4C2, "R11"); idle("R7");
    repeat (2) idle("R11");
    // Mixed traffic.
    for (int k = 0; k < 3000; k++) begin
      int rv;
      rv = $urandom_range(0, 15);
      step(rv != 0, rv == 1 || rv == 6, rv == 2 || rv == 6, rv == 3 || rv == 7,
           rv == 4, AW'($urandom_range(0, 2047)), "R9");
    end
    @(negedge clk);
    compare(lastTag);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: fetchAddr=%h expected run to complete", fetchAddr);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule